// File: doc/BRIEF.md
# Parallel Self-Synchronizing Descrambler

This block sits on the receive side of a serial link and undoes a multiplicative scrambler. Each clock it can take one word of scrambled bits, with the earliest bit on the line in bit 0. It returns the original data word one cycle later. Every recovered bit is the XOR of the received bit at the same position and two earlier received bits. Those earlier bits come from lower positions of the same word or from the previous valid word. The previous word's tail is kept in a short history register.

Only received bits feed the recurrence, so there is no feedback loop and the block needs no seed. Once the far tap's worth of bits has passed, the output follows the transmitter's data, whatever state the far-end scrambler started in. A single bit error on the line shows up at three output positions: the position of the bad bit, and the positions the near tap and the far tap lie after it.

The polynomial is set by two delay parameters that must match the scrambler. The default is x^3+x+1 (delays 2 and 3) on a 4-bit word. A 64-bit link using x^58+x^19+1 sets delays 39 and 58 with a width of 64. The parameters must satisfy 1 <= TAP_NEAR < TAP_FAR <= W.

Top module: `scr_rx_descrambler`

## Requirements
- R1: For each accepted word, out_word bit i equals the received stream bit at position i XOR the stream bits TAP_NEAR and TAP_FAR positions earlier. The stream is formed from valid words only, bit 0 earliest. Before the first valid word after reset, the earlier bits count as zero.
- R2: While rst_n is low, out_valid is 0 and out_word is all zeros, and the stored history is cleared to zero.
- R3: out_valid is high exactly one cycle after a cycle with in_valid high, and out_word carries that word's result in the same cycle.
- R4: Cycles with in_valid low do not advance the history. A word's result does not depend on how many idle cycles came before it.
- R5: out_word keeps its value through any cycle that follows a cycle with in_valid low.
- R6: Take a scrambler with the same taps, started from any seed, computing S(t) = D(t) XOR S(t-TAP_NEAR) XOR S(t-TAP_FAR). Fed its output, the block returns that scrambler's data on every valid word from the second one after reset onward.
- R7: Inverting one received bit changes exactly three recovered bits, at stream offsets 0, TAP_NEAR and TAP_FAR from the inverted bit (0, 2 and 3 by default).
- R8: An all-zero input word accepted after an all-zero history yields an all-zero output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_word holds a scrambled word this cycle |
| in_word | input | W | Scrambled word, bit 0 earliest on the line |
| out_valid | output | 1 | out_word holds a newly recovered word |
| out_word | output | W | Recovered data word, bit 0 earliest |

## Verification
The assertions assume that in_valid and in_word are known on every clock edge once reset is released. They also assume reset is held low from time zero through the first edges. The bench drives both inputs on the falling edge from defined values only, starting under reset. It mixes random data, random seeds and random idle gaps with directed all-zero words and a single injected line error. Any word with in_valid low still carries a defined value.

// File: rtl/scr_rx_descrambler.sv
module scr_rx_descrambler #(
  parameter int W        = 4,
  parameter int TAP_NEAR = 2,
  parameter int TAP_FAR  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  output logic [W-1:0] out_word
);

  logic [TAP_FAR-1:0]   tail;
  logic [W+TAP_FAR-1:0] line;
  logic [W-1:0]         plain;

  assign line = {in_word, tail};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign plain[i] = line[TAP_FAR+i] ^ line[TAP_FAR+i-TAP_NEAR] ^ line[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail      <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        tail     <= in_word[W-1:W-TAP_FAR];
        out_word <= plain;
      end
    end
  end

endmodule

// File: rtl/scr_rx_descrambler_chk.sv
module scr_rx_descrambler_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_word,
  input logic         out_valid,
  input logic [W-1:0] out_word
);

  logic prev_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_zero <= 1'b1;
    else if (in_valid) prev_zero <= (in_word == '0);
  end

  a_r2_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_word == '0));

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(out_word));

  a_r8_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_word) == '0 && $past(prev_zero))
      |-> (out_word == '0));

endmodule

bind scr_rx_descrambler scr_rx_descrambler_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_word(out_word)
);

// File: tb/tb_scr_rx_descrambler.sv
module tb_scr_rx_descrambler;
  localparam int W = 4;
  localparam int A = 2;
  localparam int B = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         out_valid;
  logic [W-1:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] tx_hist;
  logic [63:0] rx_hist;

  scr_rx_descrambler #(.W(W), .TAP_NEAR(A), .TAP_FAR(B)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble(input logic [W-1:0] d, output logic [W-1:0] s);
    for (int i = 0; i < W; i++) begin
      s[i] = d[i] ^ tx_hist[A-1] ^ tx_hist[B-1];
      tx_hist = {tx_hist[62:0], s[i]};
    end
  endtask

  task automatic ref_desc(input logic [W-1:0] s, output logic [W-1:0] d);
    for (int i = 0; i < W; i++) begin
      d[i] = s[i] ^ rx_hist[A-1] ^ rx_hist[B-1];
      rx_hist = {rx_hist[62:0], s[i]};
    end
  endtask

  task automatic tick(input logic v, input logic [W-1:0] w);
    @(negedge clk);
    in_valid = v;
    in_word  = w;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_word = '0;
    rx_hist = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R2 out_valid in reset", 64'(out_valid), 64'd0);
    check("R2 out_word in reset", 64'(out_word), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [W-1:0] d, s, e, last;
    logic [63:0] errmask;
    logic [63:0] expmask;
    bit gap;
    void'($urandom(32'h5eed_1234));

    for (int seed = 0; seed < 4; seed++) begin
      do_reset();
      tx_hist = (seed == 0) ? 64'd0 : {$urandom, $urandom};
      last = '0;
      for (int k = 0; k < 40; k++) begin
        d = W'($urandom);
        scramble(d, s);
        ref_desc(s, e);
        gap = ($urandom % 3 == 0);
        if (gap) begin
          tick(1'b0, W'($urandom));
          check("R5 idle keeps out_word", 64'(out_word), 64'(last));
          check("R3 no out_valid after idle", 64'(out_valid), 64'd0);
        end
        tick(1'b1, s);
        check("R3 out_valid after word", 64'(out_valid), 64'd1);
        check(gap ? "R4 result after idle gap" : "R1 recovered bits", 64'(out_word), 64'(e));
        if (k >= 1) check("R6 matches scrambler data", 64'(out_word), 64'(d));
        last = out_word;
      end
    end

    do_reset();
    for (int k = 0; k < 3; k++) begin
      tick(1'b1, '0);
      check("R8 zero word gives zero", 64'(out_word), 64'd0);
    end

    do_reset();
    tx_hist = {$urandom, $urandom};
    errmask = '0;
    for (int k = 0; k < 12; k++) begin
      d = W'($urandom);
      scramble(d, s);
      if (k == 5) s[1] = ~s[1];
      tick(1'b1, s);
      if (k >= 1)
        for (int i = 0; i < W; i++) errmask[k*W+i] = out_word[i] ^ d[i];
    end
    expmask = '0;
    expmask[5*W+1]   = 1'b1;
    expmask[5*W+1+A] = 1'b1;
    expmask[5*W+1+B] = 1'b1;
    check("R7 error count", 64'($countones(errmask)), 64'd3);
    check("R7 error positions", errmask, expmask);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule